// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block supplies the two source operand values for the instruction sitting in the Decode stage of an in-order pipeline. A source register may have a newer value than the one in the register file, because an older instruction further down the pipeline has produced it but not yet written it back. The selector compares each source register ID with the destination IDs of five in-flight results and routes the newest matching value to the operand. The five results are the ALU result in Execute, the loaded data and the ALU result in Memory, and the loaded data and the ALU result in Writeback. When no in-flight result matches, the register file read data passes through.

The selector is purely combinational. The operand follows its inputs in the same cycle, so the Execute stage of the next cycle sees a correct value. Stall detection for loads whose data is not yet available is left to the hazard unit. That is why no load-data candidate exists in Execute. Register ID 0xF stands for "no register", and registers 0x0 to 0xE are real.

Top module: `fwd_decode_bypass`

## Requirements
- R1: When the source ID is a real register (not 0xF) equal to the Execute ALU destination, the operand is the Execute ALU value, whatever the other stages hold.
- R2: Otherwise, when it equals the Memory load destination, the operand is the Memory load data.
- R3: Otherwise, when it equals the Memory ALU destination, the operand is the Memory ALU value.
- R4: Otherwise, when it equals the Writeback load destination, the operand is the Writeback load data.
- R5: Otherwise, when it equals the Writeback ALU destination, the operand is the Writeback ALU value.
- R6: When no destination matches the source ID, the operand is that port's register file read data.
- R7: A source ID of 0xF always yields the register file read data, even when destinations also carry 0xF.
- R8: A destination ID of 0xF never matches, so a stage whose destination is 0xF has no effect on either operand.
- R9: Operand A and operand B are selected independently: each uses only its own source ID and its own register file read data, and both may bypass from the same stage.
- R10: The selection is combinational: a change on any value or ID input shows at the operands within the same cycle, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a_id | input | 4 | Source register ID of operand A (0xF = none) |
| src_b_id | input | 4 | Source register ID of operand B (0xF = none) |
| rf_a_val | input | 64 | Register file read data for operand A |
| rf_b_val | input | 64 | Register file read data for operand B |
| ex_alu_dst | input | 4 | Destination ID of the ALU result in Execute |
| ex_alu_val | input | 64 | ALU result in Execute |
| mem_load_dst | input | 4 | Destination ID of the load result in Memory |
| mem_load_val | input | 64 | Loaded data in Memory |
| mem_alu_dst | input | 4 | Destination ID of the ALU result in Memory |
| mem_alu_val | input | 64 | ALU result in Memory |
| wb_load_dst | input | 4 | Destination ID of the load result in Writeback |
| wb_load_val | input | 64 | Loaded data in Writeback |
| wb_alu_dst | input | 4 | Destination ID of the ALU result in Writeback |
| wb_alu_val | input | 64 | ALU result in Writeback |
| opnd_a | output | 64 | Selected value of operand A |
| opnd_b | output | 64 | Selected value of operand B |

## Verification
The block holds no state, so a fault shows up on the operands in the same cycle as the input pattern that exercises it. A swapped priority shows up as a stale value when two stages name the same register. A missing 0xF guard shows up as a bypassed value where register file data was expected. A crossed port shows up when the two source IDs differ. The bench therefore uses a small pool of register IDs, which makes collisions between stages frequent. It compares both operands against a behavioural priority model a few nanoseconds after each new input pattern.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Bypass candidates, index order is priority order (lowest index wins)
    typedef enum logic [2:0] {
        CAND_EX_ALU   = 3'd0,
        CAND_MEM_LOAD = 3'd1,
        CAND_MEM_ALU  = 3'd2,
        CAND_WB_LOAD  = 3'd3,
        CAND_WB_ALU   = 3'd4
    } cand_e;

    localparam int NUM_CAND = 5;

endpackage

// File: rtl/fwd_match.sv
// Compares one source ID against one in-flight destination ID.
module fwd_match #(
    parameter int          ID_W    = 4,
    parameter logic [3:0]  NONE_ID = 4'hF
) (
    input  logic [ID_W-1:0] src_id,
    input  logic [ID_W-1:0] dst_id,
    output logic            hit
);
    localparam logic [ID_W-1:0] NONE_W = ID_W'(NONE_ID);

    always_comb begin
        hit = (src_id != NONE_W) && (dst_id != NONE_W) && (src_id == dst_id);
    end
endmodule

// File: rtl/fwd_operand_sel.sv
// Picks one operand from the in-flight candidates or the register file.
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int          DATA_W  = 64,
    parameter int          ID_W    = 4,
    parameter logic [3:0]  NONE_ID = 4'hF
) (
    input  logic [ID_W-1:0]                  src_id,
    input  logic [DATA_W-1:0]                rf_val,
    input  logic [NUM_CAND-1:0][ID_W-1:0]    cand_dst,
    input  logic [NUM_CAND-1:0][DATA_W-1:0]  cand_val,
    output logic [DATA_W-1:0]                opnd
);
    localparam logic [ID_W-1:0] NONE_W = ID_W'(NONE_ID);

    typedef struct packed {
        logic              hit;
        logic [DATA_W-1:0] val;
    } pick_t;

    logic [NUM_CAND-1:0] cand_hit;
    pick_t               pick_d;

    for (genvar g = 0; g < NUM_CAND; g++) begin : g_match
        fwd_match #(
            .ID_W    (ID_W),
            .NONE_ID (NONE_ID)
        ) u_match (
            .src_id (src_id),
            .dst_id (cand_dst[g]),
            .hit    (cand_hit[g])
        );
    end

    // Walk from lowest to highest priority so the nearest producer overrides.
    always_comb begin
        pick_d = '0;
        for (int i = NUM_CAND - 1; i >= 0; i--) begin
            if (cand_hit[i]) begin
                pick_d.hit = 1'b1;
                pick_d.val = cand_val[i];
            end
        end
        opnd = pick_d.hit ? pick_d.val : rf_val;
    end

    // Port-level checks beside the selection logic
    always_comb begin
        logic any_eq;
        logic all_none;
        any_eq   = 1'b0;
        all_none = 1'b1;
        for (int k = 0; k < NUM_CAND; k++) begin
            if (cand_dst[k] == src_id) any_eq = 1'b1;
            if (cand_dst[k] != NONE_W) all_none = 1'b0;
        end
        if (src_id == NONE_W) begin
            assert_none_src_reads_rf_R7: assert (opnd == rf_val)
                else $error("R7: source 0xF did not take register file data");
        end
        if (src_id != NONE_W && cand_dst[int'(CAND_EX_ALU)] == src_id) begin
            assert_exec_alu_first_R1: assert (opnd == cand_val[int'(CAND_EX_ALU)])
                else $error("R1: Execute ALU result not chosen");
        end
        if (!any_eq) begin
            assert_no_match_reads_rf_R6: assert (opnd == rf_val)
                else $error("R6: operand not from register file without match");
        end
        if (all_none) begin
            assert_none_dst_ignored_R8: assert (opnd == rf_val)
                else $error("R8: destination 0xF acted as a producer");
        end
    end
endmodule

// File: rtl/fwd_decode_bypass.sv
// Decode-stage two-operand bypass selector.
module fwd_decode_bypass
    import fwd_pkg::*;
#(
    parameter int          DATA_W  = 64,
    parameter int          ID_W    = 4,
    parameter logic [3:0]  NONE_ID = 4'hF
) (
    input  logic [ID_W-1:0]   src_a_id,
    input  logic [ID_W-1:0]   src_b_id,
    input  logic [DATA_W-1:0] rf_a_val,
    input  logic [DATA_W-1:0] rf_b_val,
    input  logic [ID_W-1:0]   ex_alu_dst,
    input  logic [DATA_W-1:0] ex_alu_val,
    input  logic [ID_W-1:0]   mem_load_dst,
    input  logic [DATA_W-1:0] mem_load_val,
    input  logic [ID_W-1:0]   mem_alu_dst,
    input  logic [DATA_W-1:0] mem_alu_val,
    input  logic [ID_W-1:0]   wb_load_dst,
    input  logic [DATA_W-1:0] wb_load_val,
    input  logic [ID_W-1:0]   wb_alu_dst,
    input  logic [DATA_W-1:0] wb_alu_val,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int NUM_PORTS = 2;

    logic [NUM_CAND-1:0][ID_W-1:0]   cand_dst;
    logic [NUM_CAND-1:0][DATA_W-1:0] cand_val;
    logic [NUM_PORTS-1:0][ID_W-1:0]   port_src;
    logic [NUM_PORTS-1:0][DATA_W-1:0] port_rf;
    logic [NUM_PORTS-1:0][DATA_W-1:0] port_opnd;

    always_comb begin
        cand_dst[int'(CAND_EX_ALU)]   = ex_alu_dst;
        cand_val[int'(CAND_EX_ALU)]   = ex_alu_val;
        cand_dst[int'(CAND_MEM_LOAD)] = mem_load_dst;
        cand_val[int'(CAND_MEM_LOAD)] = mem_load_val;
        cand_dst[int'(CAND_MEM_ALU)]  = mem_alu_dst;
        cand_val[int'(CAND_MEM_ALU)]  = mem_alu_val;
        cand_dst[int'(CAND_WB_LOAD)]  = wb_load_dst;
        cand_val[int'(CAND_WB_LOAD)]  = wb_load_val;
        cand_dst[int'(CAND_WB_ALU)]   = wb_alu_dst;
        cand_val[int'(CAND_WB_ALU)]   = wb_alu_val;
        port_src[0] = src_a_id;
        port_src[1] = src_b_id;
        port_rf[0]  = rf_a_val;
        port_rf[1]  = rf_b_val;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        fwd_operand_sel #(
            .DATA_W  (DATA_W),
            .ID_W    (ID_W),
            .NONE_ID (NONE_ID)
        ) u_sel (
            .src_id   (port_src[p]),
            .rf_val   (port_rf[p]),
            .cand_dst (cand_dst),
            .cand_val (cand_val),
            .opnd     (port_opnd[p])
        );
    end

    assign opnd_a = port_opnd[0];
    assign opnd_b = port_opnd[1];
endmodule

// File: tb/tb_fwd_decode_bypass.sv
module tb_fwd_decode_bypass;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [3:0]  src_a_id, src_b_id;
    logic [63:0] rf_a_val, rf_b_val;
    logic [3:0]  ex_alu_dst, mem_load_dst, mem_alu_dst, wb_load_dst, wb_alu_dst;
    logic [63:0] ex_alu_val, mem_load_val, mem_alu_val, wb_load_val, wb_alu_val;
    logic [63:0] opnd_a, opnd_b;

    int total_q = 0;
    int fail_q  = 0;
    bit done_q  = 1'b0;

    fwd_decode_bypass dut (
        .src_a_id (src_a_id), .src_b_id (src_b_id),
        .rf_a_val (rf_a_val), .rf_b_val (rf_b_val),
        .ex_alu_dst (ex_alu_dst), .ex_alu_val (ex_alu_val),
        .mem_load_dst (mem_load_dst), .mem_load_val (mem_load_val),
        .mem_alu_dst (mem_alu_dst), .mem_alu_val (mem_alu_val),
        .wb_load_dst (wb_load_dst), .wb_load_val (wb_load_val),
        .wb_alu_dst (wb_alu_dst), .wb_alu_val (wb_alu_val),
        .opnd_a (opnd_a), .opnd_b (opnd_b)
    );

    // Behavioural priority model
    function automatic logic [63:0] model(input logic [3:0] s, input logic [63:0] rf,
                                          output string tag);
        if (s == 4'hF)             begin tag = "R7"; return rf; end
        if (ex_alu_dst   == s)     begin tag = "R1"; return ex_alu_val; end
        if (mem_load_dst == s)     begin tag = "R2"; return mem_load_val; end
        if (mem_alu_dst  == s)     begin tag = "R3"; return mem_alu_val; end
        if (wb_load_dst  == s)     begin tag = "R4"; return wb_load_val; end
        if (wb_alu_dst   == s)     begin tag = "R5"; return wb_alu_val; end
        tag = "R6";
        return rf;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total_q++;
        if (act !== exp) begin
            fail_q++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_both(input string extra);
        string ta, tb_;
        logic [63:0] ea, eb;
        ea = model(src_a_id, rf_a_val, ta);
        eb = model(src_b_id, rf_b_val, tb_);
        chk({ta, extra, " A"}, opnd_a, ea);
        chk({tb_, extra, " B"}, opnd_b, eb);
    endtask

    task automatic set_dsts(input logic [3:0] e, input logic [3:0] ml, input logic [3:0] ma,
                            input logic [3:0] wl, input logic [3:0] wa);
        ex_alu_dst = e; mem_load_dst = ml; mem_alu_dst = ma;
        wb_load_dst = wl; wb_alu_dst = wa;
    endtask

    function automatic logic [3:0] pick_id();
        int r;
        r = $urandom_range(0, 5);
        return (r == 5) ? 4'hF : 4'(r);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_q) begin
            total_q++;
            fail_q++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total_q - fail_q, total_q);
            $finish;
        end
    end

    initial begin
        ex_alu_val = 64'hE0E0_0000_0000_0001; mem_load_val = 64'hAAAA_0000_0000_0002;
        mem_alu_val = 64'h3333_0000_0000_0003; wb_load_val = 64'hBBBB_0000_0000_0004;
        wb_alu_val = 64'h5555_0000_0000_0005;
        rf_a_val = 64'h1111_2222_3333_4444; rf_b_val = 64'h9999_8888_7777_6666;
        src_a_id = 4'h3; src_b_id = 4'h4;
        set_dsts(4'hF, 4'hF, 4'hF, 4'hF, 4'hF);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #2;
        // Idle state: no producers, both operands from register file (R6, R8)
        chk("R8 idle A", opnd_a, rf_a_val);
        chk("R8 idle B", opnd_b, rf_b_val);

        // All stages write r3: Execute wins (R1)
        @(posedge clk); set_dsts(4'h3, 4'h3, 4'h3, 4'h3, 4'h3); #2;
        chk("R1 all-same A", opnd_a, ex_alu_val);
        // Memory load beats Memory ALU (R2)
        @(posedge clk); set_dsts(4'h1, 4'h3, 4'h3, 4'h3, 4'h3); #2;
        chk("R2 A", opnd_a, mem_load_val);
        @(posedge clk); set_dsts(4'h1, 4'h2, 4'h3, 4'h3, 4'h3); #2;
        chk("R3 A", opnd_a, mem_alu_val);
        @(posedge clk); set_dsts(4'h1, 4'h2, 4'h0, 4'h3, 4'h3); #2;
        chk("R4 A", opnd_a, wb_load_val);
        @(posedge clk); set_dsts(4'h1, 4'h2, 4'h0, 4'h5, 4'h3); #2;
        chk("R5 A", opnd_a, wb_alu_val);
        chk("R6 B", opnd_b, rf_b_val);

        // Source 0xF with every destination 0xF (R7)
        @(posedge clk); src_a_id = 4'hF; set_dsts(4'hF, 4'hF, 4'hF, 4'hF, 4'hF); #2;
        chk("R7 A", opnd_a, rf_a_val);

        // Execute destination 0xF ignored, Memory load used instead (R8)
        @(posedge clk); src_a_id = 4'h3; set_dsts(4'hF, 4'h3, 4'hF, 4'hF, 4'hF); #2;
        chk("R8 A", opnd_a, mem_load_val);

        // Both ports read the same register (R9), then different registers
        @(posedge clk); src_a_id = 4'h6; src_b_id = 4'h6; set_dsts(4'h6, 4'h1, 4'h1, 4'h1, 4'h1); #2;
        chk("R9 same A", opnd_a, ex_alu_val);
        chk("R9 same B", opnd_b, ex_alu_val);
        @(posedge clk); src_a_id = 4'h7; src_b_id = 4'h8; set_dsts(4'h7, 4'h1, 4'h1, 4'h8, 4'h1); #2;
        chk("R9 split A", opnd_a, ex_alu_val);
        chk("R9 split B", opnd_b, wb_load_val);

        // Mid-cycle change appears without a clock edge (R10)
        #1 ex_alu_val = 64'hDEAD_BEEF_0000_0010; #1;
        chk("R10 A", opnd_a, 64'hDEAD_BEEF_0000_0010);

        // Random patterns with a small ID pool for frequent collisions
        for (int n = 0; n < 3000; n++) begin
            @(posedge clk);
            src_a_id = pick_id(); src_b_id = pick_id();
            set_dsts(pick_id(), pick_id(), pick_id(), pick_id(), pick_id());
            ex_alu_val = {$urandom, $urandom}; mem_load_val = {$urandom, $urandom};
            mem_alu_val = {$urandom, $urandom}; wb_load_val = {$urandom, $urandom};
            wb_alu_val = {$urandom, $urandom};
            rf_a_val = {$urandom, $urandom}; rf_b_val = {$urandom, $urandom};
            #2;
            chk_both(" rand");
        end

        done_q = 1'b1;
        $display("%0d/%0d checks passed", total_q - fail_q, total_q);
        $finish;
    end
endmodule